// File: doc/BRIEF.md
# Timed Fast-Lock Charge-Pump Controller

This block decides, once per phase-detector cycle, whether a synthesizer's charge pump runs at its high or low current and how the loop-filter switch pin is driven. The switch pin shorts a resistor in the loop filter so the loop stays stable at the wider bandwidth that high current gives. The controller runs in the phase-detector clock domain. It takes a register image (an enable bit, a mode bit, a gain bit with its write strobe, and a 4-bit timer field) and produces a current-range select, a pin drive value and a pin output enable. A low output enable means the pin is high-impedance.

The enable and mode bits select one of three behaviours. With enable at 0, fast lock is off and the switch pin is a plain general-purpose output. With enable at 1 and mode at 0, the gain bit holds the loop in fast lock for as long as it stays set. With enable at 1 and mode at 1, writing 1 to the gain bit starts a timer of 3 + 4*timer cycles. When the timer runs out, the gain bit clears itself and the loop returns to normal bandwidth. Power-down and counter reset both cancel any fast-lock state.

Top module: `fast_lock_ctrl`

## Requirements
- R1: With fastEnable = 0, swOutEn is 1 and swDrive equals fastMode (0 drives the pin low, 1 drives it high).
- R2: With fastEnable = 1 and fastMode = 0, a stored gain bit of 1 gives swOutEn = 1 and swDrive = 0. A stored gain bit of 0 gives swOutEn = 0 (pin high-impedance).
- R3: Outside timed mode, highCurrent equals the stored gain bit (1 selects the 1 mA range, 0 the 250 uA range).
- R4: With fastEnable = 1 and fastMode = 1, a gain write of 1 starts the timer on that clock edge. From then on timerActive = 1, highCurrent = 1, swOutEn = 1 and swDrive = 0.
- R5: A timer started with timerSel = t (held constant) keeps timerActive high for exactly 3 + 4*t clock cycles. That is 3 cycles for t = 0 and 63 cycles for t = 15.
- R6: When the timer expires, the stored gain bit becomes 0, highCurrent returns to 0 and swOutEn returns to 0.
- R7: A gain write of 1 while the timer runs restarts the count, so the timer stays active for 3 + 4*t cycles after that write.
- R8: A gain write of 0 while the timer runs stops it at that edge and clears the stored gain bit.
- R9: powerDown or counterReset high at a clock edge stops the timer and clears the stored gain bit. This takes priority over a gain write in the same cycle.
- R10: Leaving timed mode (either enable or mode going to 0) stops the timer at the next edge. The stored gain bit keeps its value.
- R11: After reset the stored gain bit is 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fastEnable | input | 1 | Fast-lock enable bit |
| fastMode | input | 1 | Mode bit: manual (0) or timed (1); GPO level when disabled |
| gainWrData | input | 1 | Value written to the gain bit |
| gainWrStrobe | input | 1 | One-cycle write strobe for the gain bit |
| timerSel | input | TIMER_W | Timer field; run length is 3 + 4*timerSel cycles |
| powerDown | input | 1 | Power-down request, cancels fast lock |
| counterReset | input | 1 | Divider counter reset, cancels fast lock |
| highCurrent | output | 1 | 1 selects the high charge-pump current range |
| swDrive | output | 1 | Level driven on the switch pin |
| swOutEn | output | 1 | Switch pin output enable; 0 leaves it high-impedance |
| timerActive | output | 1 | Timed fast lock is counting |

## Verification
The timed run length is measured for timer fields 0, 1, 7 and 15. These four values separate an off-by-one at the short end, a wrong step size, and a truncated counter width at the long end. Both GPO levels and both manual gain values are applied, which checks each pin state against the mode decode. Restart and write-0 interrupt a running timer, as do power-down, counter reset and a mode change. These cases tell a true restart apart from a continued count, and tell a forced clear that beats a simultaneous write apart from one that loses to it. The bench reads the stored gain bit back after each run by switching to manual mode, which shows whether the bit was really cleared or left set.

// File: rtl/fast_lock_pkg.sv
package fast_lock_pkg;

  typedef enum logic [1:0] {
    FL_OFF    = 2'd0,
    FL_MANUAL = 2'd1,
    FL_TIMED  = 2'd2
  } flMode_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic start;
    logic stop;
  } flCmd_t;

endpackage

// File: rtl/fast_lock_timer.sv
module fast_lock_timer
  import fast_lock_pkg::*;
#(
  parameter int TIMER_W = 4,
  parameter int BASE    = 3,
  parameter int STEP    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  flCmd_t             cmd,
  input  logic [TIMER_W-1:0] timerSel,
  output logic               running,
  output logic               expire
);

  localparam int MAX_LIMIT = BASE + STEP * ((1 << TIMER_W) - 1);
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitVal;
  logic             atEnd;

  always_comb begin
    limitVal = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(timerSel);
    atEnd    = (cnt == limitVal - CNT_W'(1));
    expire   = running && atEnd && !cmd.stop && !cmd.start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cmd.stop) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cmd.start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (atEnd) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < limitVal));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !cmd.stop) |=> (running && cnt == '0));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stop |=> !running);

endmodule

// File: rtl/fast_lock_fsm.sv
module fast_lock_fsm
  import fast_lock_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   fastEnable,
  input  logic   fastMode,
  input  logic   gainWrData,
  input  logic   gainWrStrobe,
  input  logic   powerDown,
  input  logic   counterReset,
  input  logic   timerRunning,
  input  logic   timerExpire,
  output flCmd_t cmd,
  output logic   highCurrent,
  output logic   swDrive,
  output logic   swOutEn
);

  flMode_e mode;
  logic    gainQ;
  logic    forceOff;

  always_comb begin
    if (!fastEnable)     mode = FL_OFF;
    else if (!fastMode)  mode = FL_MANUAL;
    else                 mode = FL_TIMED;
    forceOff = powerDown || counterReset;
  end

  always_comb begin
    cmd.start = (mode == FL_TIMED) && gainWrStrobe && gainWrData && !forceOff;
    cmd.stop  = forceOff || (mode != FL_TIMED) || (gainWrStrobe && !gainWrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gainQ <= 1'b0;
    else if (forceOff)      gainQ <= 1'b0;
    else if (gainWrStrobe)  gainQ <= gainWrData;
    else if (timerExpire)   gainQ <= 1'b0;
  end

  always_comb begin
    unique case (mode)
      FL_OFF: begin
        highCurrent = gainQ;
        swDrive     = fastMode;
        swOutEn     = 1'b1;
      end
      FL_MANUAL: begin
        highCurrent = gainQ;
        swDrive     = 1'b0;
        swOutEn     = gainQ;
      end
      default: begin
        highCurrent = timerRunning;
        swDrive     = 1'b0;
        swOutEn     = timerRunning;
      end
    endcase
  end

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerRunning) |-> $past(gainWrStrobe && gainWrData && fastEnable && fastMode));

  // R6
  expire_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(timerRunning) && $past(fastEnable && fastMode && !forceOff && !gainWrStrobe))
      |-> !gainQ);

  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |=> (!highCurrent && !timerRunning));

  // R10
  leave_timed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(fastEnable && fastMode)) |=> !timerRunning);

endmodule

// File: rtl/fast_lock_ctrl.sv
module fast_lock_ctrl
  import fast_lock_pkg::*;
#(
  parameter int TIMER_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fastEnable,
  input  logic               fastMode,
  input  logic               gainWrData,
  input  logic               gainWrStrobe,
  input  logic [TIMER_W-1:0] timerSel,
  input  logic               powerDown,
  input  logic               counterReset,
  output logic               highCurrent,
  output logic               swDrive,
  output logic               swOutEn,
  output logic               timerActive
);

  flCmd_t cmd;
  logic   running;
  logic   expire;

  fast_lock_fsm ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .fastEnable   (fastEnable),
    .fastMode     (fastMode),
    .gainWrData   (gainWrData),
    .gainWrStrobe (gainWrStrobe),
    .powerDown    (powerDown),
    .counterReset (counterReset),
    .timerRunning (running),
    .timerExpire  (expire),
    .cmd          (cmd),
    .highCurrent  (highCurrent),
    .swDrive      (swDrive),
    .swOutEn      (swOutEn)
  );

  fast_lock_timer #(
    .TIMER_W (TIMER_W),
    .BASE    (3),
    .STEP    (4)
  ) timer_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .timerSel (timerSel),
    .running  (running),
    .expire   (expire)
  );

  assign timerActive = running;

endmodule

// File: tb/fast_lock_ctrl_tb_top.sv
module fast_lock_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastEnable = 1'b0, fastMode = 1'b0;
  logic gainWrData = 1'b0, gainWrStrobe = 1'b0;
  logic [TW-1:0] timerSel = '0;
  logic powerDown = 1'b0, counterReset = 1'b0;
  logic highCurrent, swDrive, swOutEn, timerActive;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_lock_ctrl #(.TIMER_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .fastEnable(fastEnable), .fastMode(fastMode),
    .gainWrData(gainWrData), .gainWrStrobe(gainWrStrobe), .timerSel(timerSel),
    .powerDown(powerDown), .counterReset(counterReset),
    .highCurrent(highCurrent), .swDrive(swDrive), .swOutEn(swOutEn),
    .timerActive(timerActive)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeGain(input logic v);
    gainWrData = v;
    gainWrStrobe = 1'b1;
    tick();
    gainWrStrobe = 1'b0;
  endtask

  task automatic setMode(input logic en, input logic md);
    fastEnable = en;
    fastMode = md;
    #1;
  endtask

  // counts cycles timerActive stays high, starting just after the start edge
  task automatic measureRun(output int n);
    n = 0;
    while (timerActive && n < 200) begin
      n++;
      tick();
    end
  endtask

  task automatic testReset();
    // R11
    check("R11 timerActive", int'(timerActive), 0);
    check("R11 highCurrent", int'(highCurrent), 0);
    setMode(1'b1, 1'b0);
    check("R11 gain reads 0 in manual", int'(swOutEn), 0);
    setMode(1'b0, 1'b0);
  endtask

  task automatic testGpo();
    setMode(1'b0, 1'b0);
    check("R1 outEn mode0", int'(swOutEn), 1);
    check("R1 drive mode0", int'(swDrive), 0);
    setMode(1'b0, 1'b1);
    check("R1 outEn mode1", int'(swOutEn), 1);
    check("R1 drive mode1", int'(swDrive), 1);
    writeGain(1'b1);
    check("R3 disabled gain1 high", int'(highCurrent), 1);
    check("R1 drive unaffected by gain", int'(swDrive), 1);
    writeGain(1'b0);
    check("R3 disabled gain0 low", int'(highCurrent), 0);
  endtask

  task automatic testManual();
    setMode(1'b1, 1'b0);
    writeGain(1'b1);
    check("R2 manual outEn", int'(swOutEn), 1);
    check("R2 manual drive low", int'(swDrive), 0);
    check("R3 manual high", int'(highCurrent), 1);
    repeat (70) tick();
    check("R3 manual holds", int'(highCurrent), 1);
    check("R2 manual no timer", int'(timerActive), 0);
    writeGain(1'b0);
    check("R2 manual hi-z", int'(swOutEn), 0);
    check("R3 manual low", int'(highCurrent), 0);
  endtask

  task automatic testTimed(input int t);
    int n;
    setMode(1'b1, 1'b1);
    timerSel = TW'(t);
    writeGain(1'b1);
    check("R4 timer active", int'(timerActive), 1);
    check("R4 high current", int'(highCurrent), 1);
    check("R4 pin low", int'(swOutEn && !swDrive), 1);
    measureRun(n);
    check($sformatf("R5 run length t=%0d", t), n, 3 + 4 * t);
    check("R6 current low", int'(highCurrent), 0);
    check("R6 pin hi-z", int'(swOutEn), 0);
    setMode(1'b1, 1'b0);
    check("R6 gain cleared", int'(highCurrent), 0);
  endtask

  task automatic testRestart();
    int n;
    setMode(1'b1, 1'b1);
    timerSel = TW'(2);
    writeGain(1'b1);
    repeat (6) tick();
    check("R7 still running", int'(timerActive), 1);
    writeGain(1'b1);
    measureRun(n);
    check("R7 restart length", n, 11);
  endtask

  task automatic testWriteZero();
    setMode(1'b1, 1'b1);
    timerSel = TW'(5);
    writeGain(1'b1);
    repeat (3) tick();
    writeGain(1'b0);
    check("R8 stopped", int'(timerActive), 0);
    check("R8 current low", int'(highCurrent), 0);
    setMode(1'b1, 1'b0);
    check("R8 gain cleared", int'(highCurrent), 0);
  endtask

  task automatic testForce(input bit usePd);
    setMode(1'b1, 1'b1);
    timerSel = TW'(4);
    writeGain(1'b1);
    repeat (2) tick();
    if (usePd) powerDown = 1'b1; else counterReset = 1'b1;
    writeGain(1'b1);
    powerDown = 1'b0;
    counterReset = 1'b0;
    #1;
    check(usePd ? "R9 pd stops timer" : "R9 crst stops timer", int'(timerActive), 0);
    check("R9 current low", int'(highCurrent), 0);
    setMode(1'b1, 1'b0);
    check("R9 gain cleared", int'(highCurrent), 0);
  endtask

  task automatic testLeave();
    setMode(1'b1, 1'b1);
    timerSel = TW'(6);
    writeGain(1'b1);
    repeat (2) tick();
    setMode(1'b1, 1'b0);
    tick();
    check("R10 timer stopped", int'(timerActive), 0);
    check("R10 gain kept", int'(highCurrent), 1);
    writeGain(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testGpo();
    testManual();
    testTimed(0);
    testTimed(1);
    testTimed(7);
    testTimed(15);
    testRestart();
    testWriteZero();
    testForce(1'b1);
    testForce(1'b0);
    testLeave();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule